// File: doc/BRIEF.md
# Split-Queue Virtual Channel Egress Scheduler

This block sits on the transmit side of a link port. Every virtual channel (VC) owns two FIFOs, a main queue and a bypass queue, and each queue has its own counter of credits granted by the link partner. A packet is one data word that carries a VC number and a bypassable flag. It is steered into one of the two queues of its VC. One credit is spent for each packet sent, and the partner returns credits one at a time on per-queue pulse inputs.

Each cycle the block finds the VCs whose main or bypass head packet has credit. It picks one VC with a policy chosen in a configuration register: strict priority, round robin or weighted round robin. From the chosen VC it then sends the bypass head before the main head. Bypassable packets therefore get past a main queue that is stalled for lack of credit, while non-bypassable traffic keeps its order within a VC.

Top module: `vc_bypass_sched`

## Requirements
- R1: A packet with `in_byp`=1 is written to its VC's bypass queue only when that VC's main queue holds a packet and its main credit count is zero. Otherwise, and always when `in_byp`=0, it is written to the main queue.
- R2: A queue sends only while its credit count is at least one. Each packet sent takes one credit, and each cycle with the queue's `ret_main`/`ret_byp` bit high adds one credit.
- R3: A bypass-queue head that has credit is sent even while the main head of the same VC has none. A packet leaves on `out_*` in the cycle after some queue became eligible.
- R4: Packets in one VC's main queue leave in the order they arrived.
- R5: When both queues of the granted VC are eligible, the bypass head is sent first (`out_byp`=1).
- R6: With mode 0 (strict priority), the highest-numbered eligible VC is granted.
- R7: With mode 1 (round robin, also used for code 3), the search starts at the VC after the last one granted. After reset it starts at VC 0.
- R8: With mode 2 (weighted round robin), each VC may take up to its 4-bit weight of grants per round, and a weight of 0 counts as 1. The grant stays on the current VC while it has grants left, and the round's allowances are reloaded once no eligible VC has any left.
- R9: A credit counter stops at `cfg_cred_max`. A return pulse at that value sets a sticky bit in `cred_err` that only reset clears. Bit v is the main queue of VC v, and bit NUM_VC+v is the bypass queue of VC v.
- R10: After reset, `out_valid`=0, all credits and `cred_err` are zero, all queues are empty, the mode is round robin, every weight is 1 and the credit limit is all ones.
- R11: `in_ready` is low when the queue that the steering rule would pick for `in_vc`/`in_byp` is full. At most one packet is sent per cycle.
- R12: `cfg_mode`, `cfg_weight` and `cfg_cred_max` take effect only in a cycle with `cfg_wr` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the configuration fields |
| cfg_mode | input | 2 | 0 strict, 1 round robin, 2 weighted, 3 round robin |
| cfg_weight | input | NUM_VC*4 | Per-VC weight, VC v in bits [4v+3:4v] |
| cfg_cred_max | input | CRED_W | Credit counter ceiling |
| in_valid | input | 1 | Packet offered |
| in_vc | input | $clog2(NUM_VC) | Target VC of the offered packet |
| in_byp | input | 1 | Packet may be bypassed |
| in_data | input | DATA_W | Packet word |
| in_ready | output | 1 | Selected queue has room |
| ret_main | input | NUM_VC | One credit returned per main queue |
| ret_byp | input | NUM_VC | One credit returned per bypass queue |
| out_valid | output | 1 | Packet sent this cycle |
| out_vc | output | $clog2(NUM_VC) | VC of the sent packet |
| out_byp | output | 1 | Sent from the bypass queue |
| out_data | output | DATA_W | Sent packet word |
| cred_err | output | 2*NUM_VC | Sticky credit-overflow flags |

## Verification
The bench builds the block with NUM_VC=3, DEPTH=4, DATA_W=8 and CRED_W=3. Three channels in a two-bit index make the round-robin and weighted searches wrap past an unused code. A depth of four lets a queue fill with a handful of writes. A three-bit credit field puts the ceiling close enough that saturation and the sticky overflow flag are reached in a few return pulses.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

  localparam int unsigned WGT_W = 4;

  typedef enum logic [1:0] {
    ARB_STRICT = 2'd0,
    ARB_RR     = 2'd1,
    ARB_WRR    = 2'd2,
    ARB_RR_ALT = 2'd3
  } arb_mode_e;

endpackage

// File: rtl/vcs_fifo.sv
module vcs_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wr ? bump(wp_q) : wp_q;
    rp_d  = rd ? bump(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (wr && !rd) cnt_d = cnt_q + 1'b1;
    else if (rd && !wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp_q] <= wdata;
  end

  assign head  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/vcs_credit.sv
module vcs_credit #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          err
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          ovf;

  always_comb begin
    cnt_d = cnt_q;
    ovf   = 1'b0;
    if (inc && !dec) begin
      if (cnt_q >= limit) ovf = 1'b1;
      else cnt_d = cnt_q + 1'b1;
    end else if (dec && !inc) begin
      cnt_d = cnt_q - 1'b1;
    end
    err_d = err_q | ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign cnt = cnt_q;
  assign err = err_q;

endmodule

// File: rtl/vcs_arbiter.sv
module vcs_arbiter
  import vcs_pkg::*;
#(
  parameter int N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       elig,
  input  arb_mode_e          mode,
  input  logic [N*WGT_W-1:0] weights,
  output logic [N-1:0]       gnt
);

  localparam int IW = $clog2(N);

  logic [IW-1:0]    last_q, last_d, rr_start, idx;
  logic [WGT_W-1:0] rem_q [N];
  logic [WGT_W-1:0] rem_d [N];
  logic [WGT_W-1:0] reload [N];
  logic [N-1:0]     live;
  logic             have;

  function automatic logic [IW-1:0] pick(input logic [N-1:0] m,
                                         input logic [IW-1:0] start);
    logic [IW-1:0] r;
    int s;
    r = '0;
    for (int k = N - 1; k >= 0; k--) begin
      s = int'(start) + k;
      if (s >= N) s = s - N;
      if (m[s]) r = s[IW-1:0];
    end
    return r;
  endfunction

  always_comb begin
    have     = |elig;
    rr_start = (last_q == IW'(N - 1)) ? '0 : last_q + 1'b1;
    for (int v = 0; v < N; v++) begin
      reload[v] = (weights[v*WGT_W +: WGT_W] == '0) ? WGT_W'(1)
                                                    : weights[v*WGT_W +: WGT_W];
      live[v]   = elig[v] && (rem_q[v] != '0);
      rem_d[v]  = rem_q[v];
    end
    idx = '0;
    case (mode)
      ARB_STRICT: begin
        for (int v = 0; v < N; v++) begin
          if (elig[v]) idx = v[IW-1:0];
        end
      end
      ARB_WRR: begin
        if (|live) begin
          idx        = pick(live, last_q);
          rem_d[idx] = rem_q[idx] - 1'b1;
        end else begin
          idx = pick(elig, rr_start);
          for (int v = 0; v < N; v++) rem_d[v] = reload[v];
          rem_d[idx] = reload[idx] - 1'b1;
        end
      end
      default: idx = pick(elig, rr_start);
    endcase
    last_d = idx;
    gnt    = '0;
    if (have) gnt[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IW'(N - 1);
      for (int v = 0; v < N; v++) rem_q[v] <= '0;
    end else if (have) begin
      last_q <= last_d;
      for (int v = 0; v < N; v++) rem_q[v] <= rem_d[v];
    end
  end

endmodule

// File: rtl/vc_bypass_sched.sv
module vc_bypass_sched
  import vcs_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int CRED_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [1:0]                cfg_mode,
  input  logic [NUM_VC*WGT_W-1:0]   cfg_weight,
  input  logic [CRED_W-1:0]         cfg_cred_max,
  input  logic                      in_valid,
  input  logic [$clog2(NUM_VC)-1:0] in_vc,
  input  logic                      in_byp,
  input  logic [DATA_W-1:0]         in_data,
  output logic                      in_ready,
  input  logic [NUM_VC-1:0]         ret_main,
  input  logic [NUM_VC-1:0]         ret_byp,
  output logic                      out_valid,
  output logic [$clog2(NUM_VC)-1:0] out_vc,
  output logic                      out_byp,
  output logic [DATA_W-1:0]         out_data,
  output logic [2*NUM_VC-1:0]       cred_err
);

  localparam int VC_W = $clog2(NUM_VC);

  arb_mode_e                 mode_q;
  logic [NUM_VC*WGT_W-1:0]   weight_q;
  logic [CRED_W-1:0]         cmax_q;

  logic [DATA_W-1:0]         main_head [NUM_VC];
  logic [DATA_W-1:0]         byp_head  [NUM_VC];
  logic [NUM_VC-1:0]         main_empty, main_full, byp_empty, byp_full;
  logic [NUM_VC-1:0]         wr_m, wr_b, rd_m, rd_b, rdy_v;
  logic [NUM_VC-1:0]         elig_m, elig_b, elig, gnt;
  logic [NUM_VC-1:0]         err_m, err_b;
  logic [NUM_VC*CRED_W-1:0]  cm_flat, cb_flat;

  logic                      fire;
  logic [VC_W-1:0]           sel_vc;
  logic                      sel_byp;
  logic [DATA_W-1:0]         sel_data;
  logic                      out_valid_q;
  logic [VC_W-1:0]           out_vc_q;
  logic                      out_byp_q;
  logic [DATA_W-1:0]         out_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= ARB_RR;
      weight_q <= {NUM_VC{WGT_W'(1)}};
      cmax_q   <= '1;
    end else if (cfg_wr) begin
      mode_q   <= arb_mode_e'(cfg_mode);
      weight_q <= cfg_weight;
      cmax_q   <= cfg_cred_max;
    end
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic              sel_v, to_byp_v;
    logic [CRED_W-1:0] cm_v, cb_v;

    assign sel_v    = (in_vc == VC_W'(v));
    assign to_byp_v = in_byp && !main_empty[v] && (cm_v == '0);
    assign wr_b[v]  = in_valid && sel_v && to_byp_v && !byp_full[v];
    assign wr_m[v]  = in_valid && sel_v && !to_byp_v && !main_full[v];
    assign rdy_v[v] = sel_v && (to_byp_v ? !byp_full[v] : !main_full[v]);

    assign elig_m[v] = !main_empty[v] && (cm_v != '0);
    assign elig_b[v] = !byp_empty[v] && (cb_v != '0);
    assign rd_b[v]   = gnt[v] && elig_b[v];
    assign rd_m[v]   = gnt[v] && !elig_b[v] && elig_m[v];

    assign cm_flat[v*CRED_W +: CRED_W] = cm_v;
    assign cb_flat[v*CRED_W +: CRED_W] = cb_v;
    assign cred_err[v]          = err_m[v];
    assign cred_err[NUM_VC + v] = err_b[v];

    vcs_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_mq (
      .clk(clk), .rst_n(rst_n), .wr(wr_m[v]), .wdata(in_data), .rd(rd_m[v]),
      .head(main_head[v]), .empty(main_empty[v]), .full(main_full[v]));

    vcs_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_bq (
      .clk(clk), .rst_n(rst_n), .wr(wr_b[v]), .wdata(in_data), .rd(rd_b[v]),
      .head(byp_head[v]), .empty(byp_empty[v]), .full(byp_full[v]));

    vcs_credit #(.CW(CRED_W)) u_mc (
      .clk(clk), .rst_n(rst_n), .inc(ret_main[v]), .dec(rd_m[v]),
      .limit(cmax_q), .cnt(cm_v), .err(err_m[v]));

    vcs_credit #(.CW(CRED_W)) u_bc (
      .clk(clk), .rst_n(rst_n), .inc(ret_byp[v]), .dec(rd_b[v]),
      .limit(cmax_q), .cnt(cb_v), .err(err_b[v]));
  end

  assign in_ready = |rdy_v;
  assign elig     = elig_m | elig_b;

  vcs_arbiter #(.N(NUM_VC)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .mode(mode_q),
    .weights(weight_q), .gnt(gnt));

  always_comb begin
    fire     = |gnt;
    sel_vc   = '0;
    sel_byp  = 1'b0;
    sel_data = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (gnt[v]) begin
        sel_vc   = v[VC_W-1:0];
        sel_byp  = elig_b[v];
        sel_data = elig_b[v] ? byp_head[v] : main_head[v];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid_q <= 1'b0;
    else        out_valid_q <= fire;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      out_vc_q   <= sel_vc;
      out_byp_q  <= sel_byp;
      out_data_q <= sel_data;
    end
  end

  assign out_valid = out_valid_q;
  assign out_vc    = out_vc_q;
  assign out_byp   = out_byp_q;
  assign out_data  = out_data_q;

endmodule

// File: rtl/vcs_checker.sv
module vcs_checker #(
  parameter int NUM_VC = 4,
  parameter int CRED_W = 6,
  parameter int VC_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     out_valid,
  input logic [VC_W-1:0]          out_vc,
  input logic                     out_byp,
  input logic [2*NUM_VC-1:0]      cred_err,
  input logic [NUM_VC*CRED_W-1:0] cm_flat,
  input logic [NUM_VC*CRED_W-1:0] cb_flat,
  input logic [NUM_VC-1:0]        elig_m,
  input logic [NUM_VC-1:0]        elig_b,
  input logic [NUM_VC-1:0]        gnt,
  input logic [1:0]               mode
);

  logic [NUM_VC*CRED_W-1:0] cm_p, cb_p;
  logic [NUM_VC-1:0]        em_p, eb_p;
  logic [2*NUM_VC-1:0]      err_p;
  logic [1:0]               mode_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_p   <= '0;
      cb_p   <= '0;
      em_p   <= '0;
      eb_p   <= '0;
      err_p  <= '0;
      mode_p <= 2'd1;
    end else begin
      cm_p   <= cm_flat;
      cb_p   <= cb_flat;
      em_p   <= elig_m;
      eb_p   <= elig_b;
      err_p  <= cred_err;
      mode_p <= mode;
    end
  end

  assert_send_has_credit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_byp ? cb_p[out_vc*CRED_W +: CRED_W]
                            : cm_p[out_vc*CRED_W +: CRED_W]) != '0));

  assert_send_follows_elig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (|(em_p | eb_p)));

  assert_bypass_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_byp) |-> !eb_p[out_vc]);

  assert_strict_highest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_p == 2'd0) |-> ((((em_p | eb_p) >> out_vc) >> 1) == '0));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cred_err & err_p) == err_p);

  assert_one_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

endmodule

bind vc_bypass_sched vcs_checker #(
  .NUM_VC(NUM_VC), .CRED_W(CRED_W), .VC_W($clog2(NUM_VC))
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_vc(out_vc),
  .out_byp(out_byp), .cred_err(cred_err), .cm_flat(cm_flat), .cb_flat(cb_flat),
  .elig_m(elig_m), .elig_b(elig_b), .gnt(gnt), .mode(mode_q)
);

// File: tb/sim_vc_bypass_sched.sv
module sim_vc_bypass_sched;

  localparam int NV = 3;
  localparam int VW = 2;
  localparam int DW = 8;
  localparam int CW = 3;

  // {npush[1:0], b0, b1, main_cred[2:0], byp_cred[2:0], exp_cnt[2:0], exp_last_byp}
  localparam logic [13:0] STEER_TAB [6] = '{
    {2'd1, 1'b1, 1'b0, 3'd0, 3'd1, 3'd0, 1'b0},
    {2'd1, 1'b1, 1'b0, 3'd1, 3'd0, 3'd1, 1'b0},
    {2'd2, 1'b0, 1'b1, 3'd0, 3'd1, 3'd1, 1'b1},
    {2'd2, 1'b0, 1'b1, 3'd2, 3'd0, 3'd2, 1'b0},
    {2'd2, 1'b0, 1'b0, 3'd0, 3'd1, 3'd0, 1'b0},
    {2'd2, 1'b1, 1'b1, 3'd0, 3'd1, 3'd1, 1'b1}
  };
  localparam int WRR_EXP [12] = '{0, 0, 1, 2, 0, 0, 1, 2, 1, 2, 1, 2};

  logic           clk, rst_n;
  logic           cfg_wr;
  logic [1:0]     cfg_mode;
  logic [NV*4-1:0] cfg_weight;
  logic [CW-1:0]  cfg_cred_max;
  logic           in_valid, in_byp, in_ready;
  logic [VW-1:0]  in_vc;
  logic [DW-1:0]  in_data;
  logic [NV-1:0]  ret_main, ret_byp;
  logic           out_valid, out_byp;
  logic [VW-1:0]  out_vc;
  logic [DW-1:0]  out_data;
  logic [2*NV-1:0] cred_err;

  int n_chk, n_err, log_n, base;
  bit done;
  int log_vc [256];
  int log_byp [256];
  int log_data [256];

  vc_bypass_sched #(.NUM_VC(NV), .DEPTH(4), .DATA_W(DW), .CRED_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_weight(cfg_weight), .cfg_cred_max(cfg_cred_max), .in_valid(in_valid),
    .in_vc(in_vc), .in_byp(in_byp), .in_data(in_data), .in_ready(in_ready),
    .ret_main(ret_main), .ret_byp(ret_byp), .out_valid(out_valid),
    .out_vc(out_vc), .out_byp(out_byp), .out_data(out_data), .cred_err(cred_err));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    #5;
    if (rst_n && out_valid && log_n < 256) begin
      log_vc[log_n]   = int'(out_vc);
      log_byp[log_n]  = int'(out_byp);
      log_data[log_n] = int'(out_data);
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_wr = 0; cfg_mode = 2'd1; cfg_weight = '0; cfg_cred_max = '1;
    in_valid = 0; in_vc = '0; in_byp = 0; in_data = '0;
    ret_main = '0; ret_byp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    base = log_n;
  endtask

  task automatic push(input int vc, input logic byp, input int d);
    in_valid = 1'b1; in_vc = VW'(vc); in_byp = byp; in_data = DW'(d);
    @(negedge clk);
    in_valid = 1'b0; in_byp = 1'b0;
  endtask

  task automatic ret(input logic [NV-1:0] mm, input logic [NV-1:0] mb);
    ret_main = mm; ret_byp = mb;
    @(negedge clk);
    ret_main = '0; ret_byp = '0;
  endtask

  task automatic cfg(input logic [1:0] m, input logic [NV*4-1:0] w, input logic [CW-1:0] mx);
    cfg_mode = m; cfg_weight = w; cfg_cred_max = mx; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic chk_out(input int k, input int vc, input int byp, input int d, input string req);
    chk(log_vc[base+k] == vc, req, log_vc[base+k], vc);
    chk(log_byp[base+k] == byp, req, log_byp[base+k], byp);
    chk(log_data[base+k] == d, req, log_data[base+k], d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    logic [13:0] e;
    n_chk = 0; n_err = 0; log_n = 0; done = 0;

    // R10 reset state
    do_reset();
    chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
    chk(cred_err == '0, "R10 cred_err", int'(cred_err), 0);
    chk(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);

    // R1 / R3 steering table on VC 1
    for (int i = 0; i < 6; i++) begin
      e = STEER_TAB[i];
      do_reset();
      for (int j = 0; j < int'(e[9:7]); j++) ret(3'b010, 3'b000);
      for (int j = 0; j < int'(e[6:4]); j++) ret(3'b000, 3'b010);
      push(1, e[11], 8'hA0 + i);
      if (e[13:12] == 2'd2) push(1, e[10], 8'hB0 + i);
      repeat (10) @(negedge clk);
      chk(log_n - base == int'(e[3:1]), "R1 steer count", log_n - base, int'(e[3:1]));
      if (e[3:1] != 0)
        chk(log_byp[log_n-1] == int'(e[0]), "R3 steer queue", log_byp[log_n-1], int'(e[0]));
    end

    // R4 main-queue order
    do_reset();
    push(0, 0, 1); push(0, 0, 2); push(0, 0, 3);
    ret(3'b001, 0); ret(3'b001, 0); ret(3'b001, 0);
    repeat (6) @(negedge clk);
    chk(log_n - base == 3, "R4 count", log_n - base, 3);
    chk_out(0, 0, 0, 1, "R4 first");
    chk_out(1, 0, 0, 2, "R4 second");
    chk_out(2, 0, 0, 3, "R4 third");

    // R5 bypass head before main head
    do_reset();
    push(2, 0, 8'h21); push(2, 1, 8'h22);
    ret(3'b100, 3'b100);
    repeat (6) @(negedge clk);
    chk_out(0, 2, 1, 8'h22, "R5 bypass first");
    chk_out(1, 2, 0, 8'h21, "R5 main second");

    // R7 round robin after reset; R12 mode input ignored without cfg_wr
    do_reset();
    cfg_mode = 2'd0;
    push(0, 0, 8'h10); push(1, 0, 8'h11); push(2, 0, 8'h12);
    ret(3'b111, 0);
    repeat (6) @(negedge clk);
    chk_out(0, 0, 0, 8'h10, "R12 no write keeps RR");
    chk_out(1, 1, 0, 8'h11, "R7 rr");
    chk_out(2, 2, 0, 8'h12, "R7 rr");

    // R6 strict priority
    do_reset();
    cfg(2'd0, 12'h111, 3'd7);
    push(0, 0, 8'h30); push(1, 0, 8'h31); push(2, 0, 8'h32);
    ret(3'b111, 0);
    repeat (6) @(negedge clk);
    chk_out(0, 2, 0, 8'h32, "R6 strict");
    chk_out(1, 1, 0, 8'h31, "R6 strict");
    chk_out(2, 0, 0, 8'h30, "R6 strict");

    // R7 round robin, two rounds
    do_reset();
    for (int j = 0; j < 2; j++) for (int v = 0; v < NV; v++) push(v, 0, v * 16 + j);
    ret(3'b111, 0); ret(3'b111, 0);
    repeat (10) @(negedge clk);
    chk(log_n - base == 6, "R7 count", log_n - base, 6);
    for (int k = 0; k < 6; k++)
      chk(log_vc[base+k] == k % 3, "R7 rotation", log_vc[base+k], k % 3);

    // R8 weighted round robin: weights VC0=2 VC1=1 VC2=0
    do_reset();
    cfg(2'd2, {4'd0, 4'd1, 4'd2}, 3'd7);
    for (int v = 0; v < NV; v++) for (int j = 0; j < 4; j++) push(v, 0, v * 16 + j);
    for (int j = 0; j < 4; j++) ret(3'b111, 0);
    repeat (20) @(negedge clk);
    chk(log_n - base == 12, "R8 count", log_n - base, 12);
    for (int k = 0; k < 12; k++)
      chk(log_vc[base+k] == WRR_EXP[k], "R8 weighted order", log_vc[base+k], WRR_EXP[k]);

    // R9 saturation and sticky error
    do_reset();
    cfg(2'd1, 12'h111, 3'd3);
    ret(3'b001, 0); ret(3'b001, 0); ret(3'b001, 0);
    chk(cred_err == '0, "R9 no error at limit", int'(cred_err), 0);
    ret(3'b001, 0);
    chk(cred_err == 6'b000001, "R9 overflow flag", int'(cred_err), 1);
    for (int j = 0; j < 4; j++) push(0, 0, 8'h40 + j);
    repeat (10) @(negedge clk);
    chk(log_n - base == 3, "R9 saturated count", log_n - base, 3);
    chk(cred_err == 6'b000001, "R9 sticky", int'(cred_err), 1);

    // R11 full queue, R1 bypass target, R2 credit-limited sends
    do_reset();
    for (int j = 0; j < 4; j++) push(1, 0, 8'h50 + j);
    in_vc = 2'd1; in_byp = 1'b0; #1;
    chk(in_ready == 1'b0, "R11 full main", int'(in_ready), 0);
    in_byp = 1'b1; #1;
    chk(in_ready == 1'b1, "R1 bypass room", int'(in_ready), 1);
    in_vc = 2'd0; in_byp = 1'b0; #1;
    chk(in_ready == 1'b1, "R11 other vc", int'(in_ready), 1);
    @(negedge clk);
    ret(3'b010, 0); ret(3'b010, 0);
    repeat (10) @(negedge clk);
    chk(log_n - base == 2, "R2 credit-limited", log_n - base, 2);
    chk_out(1, 1, 0, 8'h51, "R2 second sent");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule